// File: doc/BRIEF.md
# Display Register Command-Stream Sequencer

This block executes a compact mode-set program held in a small internal list memory. Each 16-bit list word is either a command or one of its operands. The sequencer walks the list from address 0 and turns every command into byte or word transactions on a simple I/O bus: single and repeated writes to one port, reads whose result is dropped, index-packed word writes, index/value byte pairs, and read-modify-write updates that apply an AND mask and then an XOR mask.

Software or a boot controller fills the list through a plain load port, then pulses `start`. The block reports `busy` while it runs. It raises `done` when it reaches the end-of-list word and `err` when it meets an opcode it does not know. The I/O bus is a valid/ready request channel. The sequencer raises `io_valid` with the address, direction, width and write data, and holds all of them unchanged until `io_ready` is high at a rising clock edge. That edge is the single transfer of the request. A read takes `io_rdata` on the same edge. The target may stall by holding `io_ready` low for any number of cycles, and no new list word is consumed while a request is outstanding.

Top module: `modeset_seq`

## Requirements
- R1: After reset `busy`, `done`, `err` and `io_valid` are low. A `start` pulse while idle, done or in error begins execution at list address 0 and clears `done`/`err`. A `start` pulse while busy has no effect.
- R2: A word whose bits 7:4 are 0x0 ends the list. `done` then rises, `busy` falls, and both hold with no bus request until the next `start`.
- R3: A word whose bits 7:4 are 0xF is a no-op. It consumes only that word and issues no transaction.
- R4: A command word carries its major code in bits 7:4 and its minor field in bits 3:0, and bits 15:8 of that word are ignored. Major 0x1 with minor bit 3 = 0 and bit 1 = 0 is a single write: port word, then value word. Minor bit 2 = 1 selects a word write (`io_wide`=1, full value). Minor bit 2 = 0 selects a byte write (`io_wide`=0, `io_wdata` = {8'h00, value[7:0]}). Minor bit 0 has no effect.
- R5: Major 0x1 with minor bit 3 = 0 and bit 1 = 1 is a repeated write: port word, count word, then count value words, each written to the same port with the width chosen by bit 2. A count of 0 issues nothing.
- R6: Major 0x1 with minor bit 3 = 1 is a read: a port word follows, and exactly one read (`io_wr`=0, width from bit 2) is issued even when bit 1 is set. The returned data has no effect on later commands.
- R7: Major 0x2, minor 0: port, count, start index (low byte), then count values. Each value gives one word write with `io_wdata` = {value[7:0], index}. The index steps by one modulo 256 after every write.
- R8: Major 0x2, minor 1: port, count, start index, then count values. Each value gives two byte writes to the port, first {8'h00, index} and then {8'h00, value[7:0]}. The index steps by one modulo 256 after each pair.
- R9: Major 0x2, minor 2: port, AND mask, XOR mask. The block issues one byte read of the port, then one byte write of ((read[7:0] & and) ^ xor).
- R10: A major code other than 0x0, 0x1, 0x2 or 0xF, or a major 0x2 minor code above 2, stops execution. `err` rises, `busy` falls, and no further transaction is issued.
- R11: While `io_valid` is high and `io_ready` is low, `io_valid`, `io_wr`, `io_wide`, `io_addr` and `io_wdata` hold. Transactions appear on the bus in list order, one per valid/ready edge.
- R12: `ld_we` writes `ld_data` into list address `ld_addr` on a rising edge, and a later run fetches the updated word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin execution at list address 0 |
| ld_we | input | 1 | List load write enable |
| ld_addr | input | AW | List load address |
| ld_data | input | 16 | List load word |
| busy | output | 1 | Program running |
| done | output | 1 | End-of-list reached |
| err | output | 1 | Unknown opcode met |
| io_valid | output | 1 | Bus request valid |
| io_wr | output | 1 | 1 = write, 0 = read |
| io_wide | output | 1 | 1 = 16-bit, 0 = 8-bit |
| io_addr | output | 16 | Port address |
| io_wdata | output | 16 | Write data (upper byte zero on byte writes) |
| io_ready | input | 1 | Target accepts the request this edge |
| io_rdata | input | 16 | Read data, taken on the transfer edge |

## Verification
Each list word costs one cycle, and a request's `io_valid` is due in the cycle after its last operand word is fetched. The next word is fetched only in the cycle after the transfer edge. `done` or `err` is due in the cycle after the terminating word is fetched. Because a stalling target shifts every later result by its stall length, the bench does not count absolute cycles. It records each transfer at the falling edge before the rising edge on which `io_valid` and `io_ready` are both high, and it checks that a stalled request is unchanged at the next falling edge. After `done` or `err`, it compares the recorded transaction list, in order, with a list computed from the program words. A bounded wait guards each run.

// File: rtl/modeset_pkg.sv
package modeset_pkg;
  localparam int WORD_W = 16;

  localparam logic [3:0] MAJ_END = 4'h0;
  localparam logic [3:0] MAJ_IO  = 4'h1;
  localparam logic [3:0] MAJ_SPC = 4'h2;
  localparam logic [3:0] MAJ_NOP = 4'hF;

  localparam int BIT_IN    = 3;
  localparam int BIT_WIDE  = 2;
  localparam int BIT_MULTI = 1;

  localparam logic [3:0] SPC_IDXW = 4'h0;
  localparam logic [3:0] SPC_PAIR = 4'h1;
  localparam logic [3:0] SPC_MASK = 4'h2;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CMD, ST_PORT, ST_CNT, ST_IDX, ST_VAL,
    ST_PAIR, ST_AND, ST_XOR, ST_BUS, ST_DONE, ST_ERR
  } seq_st_e;

  typedef enum logic [2:0] {
    K_OUT1, K_OUTN, K_IN, K_IDXW, K_PAIR, K_MASK
  } op_kind_e;

  typedef struct packed {
    logic              wr;
    logic              wide;
    logic [WORD_W-1:0] addr;
    logic [WORD_W-1:0] data;
  } io_req_t;
endpackage

// File: rtl/modeset_store.sv
module modeset_store
  import modeset_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic              clk,
  input  logic              ld_we,
  input  logic [AW-1:0]     ld_addr,
  input  logic [WORD_W-1:0] ld_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_word
);
  localparam int DEPTH = 1 << AW;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (ld_we) mem[ld_addr] <= ld_data;
  end

  assign rd_word = mem[rd_addr];
endmodule

// File: rtl/modeset_ioport.sv
module modeset_ioport
  import modeset_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  io_req_t           req,
  output logic              xfer,
  output logic [7:0]        rd_byte,
  output logic              io_valid,
  output logic              io_wr,
  output logic              io_wide,
  output logic [WORD_W-1:0] io_addr,
  output logic [WORD_W-1:0] io_wdata,
  input  logic              io_ready,
  input  logic [WORD_W-1:0] io_rdata
);
  io_req_t    hold_q;
  logic       vld_q;
  logic [7:0] rd_q;
  logic       unused_rd_hi;

  assign unused_rd_hi = ^io_rdata[WORD_W-1:8];
  assign xfer = vld_q & io_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      hold_q <= '0;
      rd_q   <= '0;
    end else begin
      if (issue) begin
        vld_q  <= 1'b1;
        hold_q <= req;
      end else if (xfer) begin
        vld_q <= 1'b0;
      end
      if (xfer && !hold_q.wr) rd_q <= io_rdata[7:0];
    end
  end

  assign io_valid = vld_q;
  assign io_wr    = hold_q.wr;
  assign io_wide  = hold_q.wide;
  assign io_addr  = hold_q.addr;
  assign io_wdata = hold_q.data;
  assign rd_byte  = rd_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    io_valid && !io_ready |=> io_valid && $stable(io_addr) && $stable(io_wdata) && $stable(io_wr) && $stable(io_wide)); // R11
  AST_ISSUE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> !io_valid); // R11
endmodule

// File: rtl/modeset_engine.sv
module modeset_engine
  import modeset_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  output logic [AW-1:0]     pc,
  output logic              issue,
  output io_req_t           req,
  input  logic              xfer,
  input  logic [7:0]        rd_byte,
  input  logic              io_valid,
  output logic              busy,
  output logic              done,
  output logic              err
);
  seq_st_e           st_q, ret_q;
  op_kind_e          kind_q;
  logic              wide_q;
  logic [WORD_W-1:0] port_q, cnt_q;
  logic [7:0]        idx_q, and_q;
  logic [AW-1:0]     pc_q;
  logic [3:0]        maj, mnr;
  logic              last;

  assign maj  = word[7:4];
  assign mnr  = word[3:0];
  assign last = (cnt_q == WORD_W'(1));
  assign pc   = pc_q;

  // Transaction issue: one request per issuing state, bus idle there
  always_comb begin
    issue = 1'b0;
    req   = '0;
    case (st_q)
      ST_PORT: if (kind_q == K_IN) begin
        issue    = 1'b1;
        req.wide = wide_q;
        req.addr = word;
      end
      ST_VAL: begin
        issue    = 1'b1;
        req.wr   = 1'b1;
        req.addr = port_q;
        case (kind_q)
          K_IDXW: begin
            req.wide = 1'b1;
            req.data = {word[7:0], idx_q};
          end
          K_PAIR:  req.data = {8'h00, idx_q};
          default: begin
            req.wide = wide_q;
            req.data = wide_q ? word : {8'h00, word[7:0]};
          end
        endcase
      end
      ST_PAIR: begin
        issue    = 1'b1;
        req.wr   = 1'b1;
        req.addr = port_q;
        req.data = {8'h00, word[7:0]};
      end
      ST_AND: begin
        issue    = 1'b1;
        req.addr = port_q;
      end
      ST_XOR: begin
        issue    = 1'b1;
        req.wr   = 1'b1;
        req.addr = port_q;
        req.data = {8'h00, (rd_byte & and_q) ^ word[7:0]};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ret_q  <= ST_IDLE;
      kind_q <= K_OUT1;
      wide_q <= 1'b0;
      port_q <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
      and_q  <= '0;
      pc_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE, ST_DONE, ST_ERR: if (start) begin
          pc_q <= '0;
          st_q <= ST_CMD;
        end
        ST_CMD: begin
          pc_q   <= pc_q + 1'b1;
          wide_q <= mnr[BIT_WIDE];
          case (maj)
            MAJ_END: st_q <= ST_DONE;
            MAJ_NOP: st_q <= ST_CMD;
            MAJ_IO: begin
              st_q <= ST_PORT;
              if (mnr[BIT_IN])         kind_q <= K_IN;
              else if (mnr[BIT_MULTI]) kind_q <= K_OUTN;
              else                     kind_q <= K_OUT1;
            end
            MAJ_SPC: begin
              st_q <= ST_PORT;
              case (mnr)
                SPC_IDXW: kind_q <= K_IDXW;
                SPC_PAIR: kind_q <= K_PAIR;
                SPC_MASK: kind_q <= K_MASK;
                default:  st_q   <= ST_ERR;
              endcase
            end
            default: st_q <= ST_ERR;
          endcase
        end
        ST_PORT: begin
          pc_q   <= pc_q + 1'b1;
          port_q <= word;
          case (kind_q)
            K_IN: begin
              st_q  <= ST_BUS;
              ret_q <= ST_CMD;
            end
            K_OUT1:  st_q <= ST_VAL;
            K_MASK:  st_q <= ST_AND;
            default: st_q <= ST_CNT;
          endcase
        end
        ST_CNT: begin
          pc_q  <= pc_q + 1'b1;
          cnt_q <= word;
          if (kind_q == K_IDXW || kind_q == K_PAIR) st_q <= ST_IDX;
          else if (word == '0)                      st_q <= ST_CMD;
          else                                      st_q <= ST_VAL;
        end
        ST_IDX: begin
          pc_q  <= pc_q + 1'b1;
          idx_q <= word[7:0];
          st_q  <= (cnt_q == '0) ? ST_CMD : ST_VAL;
        end
        ST_VAL: begin
          st_q <= ST_BUS;
          if (kind_q == K_PAIR) begin
            ret_q <= ST_PAIR;
          end else begin
            pc_q <= pc_q + 1'b1;
            if (kind_q == K_OUT1) begin
              ret_q <= ST_CMD;
            end else begin
              cnt_q <= cnt_q - 1'b1;
              ret_q <= last ? ST_CMD : ST_VAL;
              if (kind_q == K_IDXW) idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_PAIR: begin
          pc_q  <= pc_q + 1'b1;
          idx_q <= idx_q + 1'b1;
          cnt_q <= cnt_q - 1'b1;
          st_q  <= ST_BUS;
          ret_q <= last ? ST_CMD : ST_VAL;
        end
        ST_AND: begin
          pc_q  <= pc_q + 1'b1;
          and_q <= word[7:0];
          st_q  <= ST_BUS;
          ret_q <= ST_XOR;
        end
        ST_XOR: begin
          pc_q  <= pc_q + 1'b1;
          st_q  <= ST_BUS;
          ret_q <= ST_CMD;
        end
        ST_BUS:  if (xfer) st_q <= ret_q;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = !(st_q inside {ST_IDLE, ST_DONE, ST_ERR});
  assign done = (st_q == ST_DONE);
  assign err  = (st_q == ST_ERR);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !io_valid); // R10
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && !busy); // R2
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    err && !start |=> err && !busy); // R10
  AST_START_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> busy && !done && !err); // R1
endmodule

// File: rtl/modeset_seq.sv
module modeset_seq
  import modeset_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [15:0]   ld_data,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          io_valid,
  output logic          io_wr,
  output logic          io_wide,
  output logic [15:0]   io_addr,
  output logic [15:0]   io_wdata,
  input  logic          io_ready,
  input  logic [15:0]   io_rdata
);
  logic [AW-1:0]     pc;
  logic [WORD_W-1:0] word;
  logic              issue, xfer;
  io_req_t           req;
  logic [7:0]        rd_byte;

  modeset_store #(.AW(AW)) u_store (
    .clk(clk), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_addr(pc), .rd_word(word)
  );

  modeset_engine #(.AW(AW)) u_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .word(word), .pc(pc),
    .issue(issue), .req(req), .xfer(xfer), .rd_byte(rd_byte),
    .io_valid(io_valid), .busy(busy), .done(done), .err(err)
  );

  modeset_ioport u_port (
    .clk(clk), .rst_n(rst_n), .issue(issue), .req(req), .xfer(xfer),
    .rd_byte(rd_byte), .io_valid(io_valid), .io_wr(io_wr), .io_wide(io_wide),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_ready(io_ready), .io_rdata(io_rdata)
  );
endmodule

// File: tb/sim_modeset_seq.sv
module sim_modeset_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        ld_we = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic        busy, done, err, io_valid, io_wr, io_wide;
  logic [15:0] io_addr, io_wdata, io_rdata;
  logic        io_ready = 1'b1;

  always #10 clk = ~clk;

  modeset_seq #(.AW(6)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .ld_we(ld_we), .ld_addr(ld_addr),
    .ld_data(ld_data), .busy(busy), .done(done), .err(err), .io_valid(io_valid),
    .io_wr(io_wr), .io_wide(io_wide), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_ready(io_ready), .io_rdata(io_rdata)
  );

  function automatic logic [15:0] rd_model(input logic [15:0] a);
    return {~a[7:0], a[7:0] ^ 8'h5A};
  endfunction
  assign io_rdata = rd_model(io_addr);

  int n_chk = 0, n_bad = 0, rmode = 0, cyc = 0;
  logic [33:0] lg [256];
  logic [33:0] ex [256];
  int lg_n = 0, ex_n = 0;
  logic [15:0] pg [64];
  int pn = 0;
  logic stall_p = 1'b0;
  logic [15:0] p_addr, p_data;

  task automatic chk(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  // bus target: ready pattern, stall hold check and transfer log
  always @(negedge clk) begin
    cyc++;
    if (stall_p)
      chk(io_valid && io_addr == p_addr && io_wdata == p_data, "R11 held request",
          {7'd0, io_valid, io_addr, io_wdata}, {7'd0, 1'b1, p_addr, p_data});
    io_ready = (rmode == 0) ? 1'b1 : ((cyc % 3) != 0);
    stall_p = io_valid && !io_ready;
    p_addr = io_addr;
    p_data = io_wdata;
    if (io_valid && io_ready && lg_n < 256) begin
      lg[lg_n] = {io_wr, io_wide, io_addr, io_wr ? io_wdata : io_rdata};
      lg_n++;
    end
  end

  task automatic pbeg();
    pn = 0;
    ex_n = 0;
  endtask
  task automatic pw(input logic [15:0] w);
    pg[pn] = w;
    pn++;
  endtask
  task automatic exp_tx(input bit wr, input bit wide, input logic [15:0] a, input logic [15:0] d);
    ex[ex_n] = {wr, wide, a, d};
    ex_n++;
  endtask
  task automatic marker();
    pw(16'h0010); pw(16'h0055); pw(16'h0077);
    exp_tx(1'b1, 1'b0, 16'h0055, 16'h0077);
  endtask

  // R12: program words enter through the load port, execution starts at 0
  task automatic load_prog();
    for (int i = 0; i < pn; i++) begin
      @(negedge clk);
      ld_we = 1'b1; ld_addr = 6'(i); ld_data = pg[i];
    end
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic run(input string tag, input bit want_err, input bit extra_start);
    int t;
    load_prog();
    lg_n = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (extra_start) begin
      repeat (3) @(negedge clk);
      chk(busy, {tag, " busy mid-run"}, {39'd0, busy}, 40'd1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (!(done || err) && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk(t < 3000, {tag, " finish"}, 40'(t), 40'd3000);
    chk(err == want_err && done == !want_err && !busy, {tag, " end state"},
        {37'd0, done, err, busy}, {37'd0, !want_err, want_err, 1'b0});
    chk(lg_n == ex_n, {tag, " count"}, 40'(lg_n), 40'(ex_n));
    for (int i = 0; i < ex_n && i < lg_n; i++)
      chk(lg[i] == ex[i], {tag, " tx"}, {6'd0, lg[i]}, {6'd0, ex[i]});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", 40'd0, 40'd1);
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v, port;
    logic [7:0] idx, am, xm;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !io_valid, "R1 reset state",
        {36'd0, busy, done, err, io_valid}, 40'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 R5 R6: every minor code of major 0x1
    for (int m = 0; m < 16; m++) begin
      pbeg();
      rmode = m % 2;
      port = 16'h03C0 + 16'(m);
      pw(16'hAB10 | 16'(m));
      pw(port);
      if ((m & 8) != 0) begin
        exp_tx(1'b0, (m & 4) != 0, port, rd_model(port));
      end else if ((m & 2) != 0) begin
        pw(16'd2);
        for (int k = 0; k < 2; k++) begin
          v = 16'hA500 + 16'(m * 16 + k);
          pw(v);
          exp_tx(1'b1, (m & 4) != 0, port, ((m & 4) != 0) ? v : {8'h00, v[7:0]});
        end
      end else begin
        v = 16'h5A00 + 16'(m * 3);
        pw(v);
        exp_tx(1'b1, (m & 4) != 0, port, ((m & 4) != 0) ? v : {8'h00, v[7:0]});
      end
      marker();
      pw(16'h0000);
      run(((m & 8) != 0) ? "R6" : ((m & 2) != 0) ? "R5" : "R4", 1'b0, 1'b0);
    end

    // R5: repeated writes with counts 0..4, both widths
    for (int w = 0; w < 2; w++)
      for (int c = 0; c < 5; c++) begin
        pbeg();
        rmode = c % 2;
        pw((w != 0) ? 16'h0016 : 16'h0012);
        pw(16'h03C4);
        pw(16'(c));
        for (int k = 0; k < c; k++) begin
          v = 16'h1234 + 16'(k) * 16'h0101;
          pw(v);
          exp_tx(1'b1, w != 0, 16'h03C4, (w != 0) ? v : {8'h00, v[7:0]});
        end
        marker();
        pw(16'h0000);
        run("R5 count sweep", 1'b0, 1'b0);
      end

    // R7: index-packed word writes, index wraps past 0xFF
    for (int c = 0; c < 5; c++) begin
      pbeg();
      rmode = 1 - (c % 2);
      pw(16'h0020); pw(16'h03D4); pw(16'(c)); pw(16'h77FE);
      idx = 8'hFE;
      for (int k = 0; k < c; k++) begin
        v = 16'h3C00 + 16'(k * 7 + 1);
        pw(v);
        exp_tx(1'b1, 1'b1, 16'h03D4, {v[7:0], idx});
        idx = idx + 8'd1;
      end
      marker();
      pw(16'h0000);
      run("R7", 1'b0, 1'b0);
    end

    // R8: index/value byte pairs
    for (int c = 0; c < 5; c++) begin
      pbeg();
      rmode = c % 2;
      pw(16'h0021); pw(16'h03C0); pw(16'(c)); pw(16'h00FF - 16'(c / 2));
      idx = 8'hFF - 8'(c / 2);
      for (int k = 0; k < c; k++) begin
        v = 16'h9100 + 16'(k * 5 + 2);
        pw(v);
        exp_tx(1'b1, 1'b0, 16'h03C0, {8'h00, idx});
        exp_tx(1'b1, 1'b0, 16'h03C0, {8'h00, v[7:0]});
        idx = idx + 8'd1;
      end
      marker();
      pw(16'h0000);
      run("R8", 1'b0, 1'b0);
    end

    // R9: masked read-modify-write over a spread of masks and ports
    for (int k = 0; k < 8; k++) begin
      pbeg();
      rmode = k % 2;
      port = 16'h03CE + 16'(k * 17);
      am = 8'((k * 37 + 15) & 255);
      xm = 8'((k * 91 + 3) & 255);
      pw(16'h0022); pw(port); pw({8'hE1, am}); pw({8'h1E, xm});
      v = rd_model(port);
      exp_tx(1'b0, 1'b0, port, v);
      exp_tx(1'b1, 1'b0, port, {8'h00, (v[7:0] & am) ^ xm});
      marker();
      pw(16'h0000);
      run("R9", 1'b0, 1'b0);
    end

    // R3: no-op words
    pbeg();
    rmode = 0;
    pw(16'h00F0); pw(16'h12F7); marker(); pw(16'h00FF); pw(16'h0000);
    run("R3", 1'b0, 1'b0);

    // R10: unknown majors and unknown special minors
    for (int j = 3; j < 15; j++) begin
      pbeg();
      rmode = j % 2;
      marker();
      pw(16'(j << 4));
      marker();
      ex_n = 1;
      pw(16'h0000);
      run("R10 major", 1'b1, 1'b0);
    end
    for (int j = 3; j < 16; j++) begin
      pbeg();
      marker();
      pw(16'h0020 | 16'(j));
      pw(16'h03C0);
      marker();
      ex_n = 1;
      pw(16'h0000);
      run("R10 minor", 1'b1, 1'b0);
    end

    // R1: restart after error, and a start during a run is ignored
    pbeg();
    rmode = 1;
    pw(16'h0016); pw(16'h0100); pw(16'd4);
    for (int k = 0; k < 4; k++) begin
      v = 16'hC000 + 16'(k);
      pw(v);
      exp_tx(1'b1, 1'b1, 16'h0100, v);
    end
    pw(16'h0000);
    run("R1 start while busy", 1'b0, 1'b1);

    // R2: done holds with the bus quiet
    repeat (5) @(negedge clk);
    chk(done && !busy && !err && !io_valid, "R2 done hold",
        {36'd0, done, busy, err, io_valid}, {36'd0, 4'b1000});

    // R12: overwrite one value word and run again
    pbeg();
    rmode = 0;
    pw(16'h0014); pw(16'h0200); pw(16'h1111); pw(16'h0000);
    exp_tx(1'b1, 1'b1, 16'h0200, 16'h1111);
    run("R12 first load", 1'b0, 1'b0);
    pg[2] = 16'h2222;
    ex[0] = {1'b1, 1'b1, 16'h0200, 16'h2222};
    run("R12 reload", 1'b0, 1'b0);

    summary();
    $finish;
  end
endmodule